// File: doc/BRIEF.md
# Hierarchical Delay Setting Stepper

This block keeps one multi-field delay setting for a single byte lane and moves it one finest unit up or down per request. The setting is split into four fields, ordered from coarsest to finest: a coarse field, a clock-delay field, a tap field and a phase-interpolator (pi) field. A step carries or borrows across the fields, much like a mixed-radix counter. Two things break the counter pattern. First, the tap field's upper bound depends on the selected memory speed. Second, a borrow out of the coarse field adds one to the clock-delay field instead of refilling it.

A leveling controller uses the block as follows. It loads a starting setting and then issues step-down or step-up strobes while it searches for a data-strobe edge. After each accepted step the block gives a one-cycle completion pulse. A step that would run past either end of the range is rejected, the setting is left unchanged, and a one-cycle error pulse is given instead.

Top module: `dly_step_unit`

## Requirements
- R1: After reset all four fields read zero, and the done and error outputs are low.
- R2: When `ld_i` is high, the next cycle shows the four load inputs on the field outputs, with no done or error pulse. A load wins over any step strobe asserted in the same cycle.
- R3: A step-down with pi above 0 decrements pi and leaves the tap, clock-delay and coarse fields unchanged.
- R4: A step-down with pi at 0 and tap above 0 sets pi to 6 and decrements tap.
- R5: A step-down with pi and tap at 0 and clock-delay above 0 sets pi to 6, sets tap to the speed-dependent maximum, and decrements clock-delay.
- R6: A step-down with pi, tap and clock-delay all at 0 and coarse above 0 sets pi to 6, sets tap to its maximum, adds one to clock-delay, and decrements coarse.
- R7: A step-down with every field at 0 leaves the setting unchanged and gives an error pulse with no done pulse.
- R8: A step-up increments pi while pi is below 6. Otherwise pi wraps to 0 and the step carries into tap. Tap increments while it is below its maximum; otherwise tap wraps to 0 and the step carries into clock-delay. Clock-delay increments while it is below the ceiling `CLK_CEIL` (default 5). Otherwise clock-delay becomes `CLK_CEIL`-1 and coarse increments.
- R9: A step-up with pi at 6, tap at its maximum, clock-delay at `CLK_CEIL` and coarse at `CRS_TOP` (default 3) leaves the setting unchanged and gives an error pulse with no done pulse.
- R10: The tap maximum follows `spd_i`: 2'b00 gives 12, 2'b01 gives 14, 2'b10 gives 18, and 2'b11 gives 12 (these are the defaults).
- R11: Each accepted step updates the fields in the cycle after the strobe. A done pulse, exactly one cycle long, appears in that same cycle.
- R12: If step-up and step-down are asserted together, only the step-down is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| up_i | input | 1 | Step-up strobe |
| dn_i | input | 1 | Step-down strobe (has priority over step-up) |
| spd_i | input | 2 | Memory speed select; chooses the tap maximum |
| ld_i | input | 1 | Load strobe |
| ld_crs_i | input | CRS_W | Coarse value to load |
| ld_clk_i | input | CLK_W | Clock-delay value to load |
| ld_tap_i | input | TAP_W | Tap value to load |
| ld_pi_i | input | PI_W | Pi value to load |
| crs_o | output | CRS_W | Coarse field |
| clk_o | output | CLK_W | Clock-delay field |
| tap_o | output | TAP_W | Tap field |
| pi_o | output | PI_W | Phase-interpolator field |
| done_o | output | 1 | One-cycle pulse after an accepted step |
| err_o | output | 1 | One-cycle pulse after a rejected step |

## Verification
A wrong internal field shows up on the field outputs in the cycle right after the step that produced it, because every field is a register driven straight to a port. A wrong borrow or carry choice therefore shows at once as a mismatched field pattern. A broken limit decision can show in two ways: a wrapped field where the setting should have held, or an error pulse swapped with a done pulse, in both cases one cycle after the strobe. A tap maximum decoded for the wrong speed only becomes visible when a borrow or a carry reaches the tap field, so the boundary tests start from settings where pi and tap are already at a limit.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;
  typedef enum logic [1:0] {
    SPD_800  = 2'd0,
    SPD_1066 = 2'd1,
    SPD_1333 = 2'd2,
    SPD_ALT  = 2'd3
  } spd_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_LOAD,
    OP_DEC,
    OP_INC
  } op_e;
endpackage

// File: rtl/dly_tap_limit.sv
module dly_tap_limit
  import dly_step_pkg::*;
#(
  parameter int TAP_W     = 5,
  parameter int TAP_M800  = 12,
  parameter int TAP_M1066 = 14,
  parameter int TAP_M1333 = 18
) (
  input  logic [1:0]       spd_i,
  output logic [TAP_W-1:0] tmax_o
);
  always_comb begin
    case (spd_e'(spd_i))
      SPD_1066: tmax_o = TAP_W'(TAP_M1066);
      SPD_1333: tmax_o = TAP_W'(TAP_M1333);
      default:  tmax_o = TAP_W'(TAP_M800);
    endcase
  end
endmodule

// File: rtl/dly_step_dec.sv
module dly_step_dec #(
  parameter int PI_W   = 3,
  parameter int TAP_W  = 5,
  parameter int CLK_W  = 3,
  parameter int CRS_W  = 2,
  parameter int PI_TOP = 6
) (
  input  logic [PI_W-1:0]  pi_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [CLK_W-1:0] clk_i,
  input  logic [CRS_W-1:0] crs_i,
  input  logic [TAP_W-1:0] tmax_i,
  output logic [PI_W-1:0]  pi_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [CLK_W-1:0] clk_o,
  output logic [CRS_W-1:0] crs_o,
  output logic             ok_o
);
  localparam logic [PI_W-1:0] PiTop = PI_W'(PI_TOP);

  always_comb begin
    pi_o  = pi_i;
    tap_o = tap_i;
    clk_o = clk_i;
    crs_o = crs_i;
    ok_o  = 1'b1;
    if (pi_i != '0) begin
      pi_o = pi_i - PI_W'(1);
    end else if (tap_i != '0) begin
      pi_o  = PiTop;
      tap_o = tap_i - TAP_W'(1);
    end else if (clk_i != '0) begin
      pi_o  = PiTop;
      tap_o = tmax_i;
      clk_o = clk_i - CLK_W'(1);
    end else if (crs_i != '0) begin
      pi_o  = PiTop;
      tap_o = tmax_i;
      clk_o = clk_i + CLK_W'(1);
      crs_o = crs_i - CRS_W'(1);
    end else begin
      ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/dly_step_inc.sv
module dly_step_inc #(
  parameter int PI_W     = 3,
  parameter int TAP_W    = 5,
  parameter int CLK_W    = 3,
  parameter int CRS_W    = 2,
  parameter int PI_TOP   = 6,
  parameter int CLK_CEIL = 5,
  parameter int CRS_TOP  = 3
) (
  input  logic [PI_W-1:0]  pi_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [CLK_W-1:0] clk_i,
  input  logic [CRS_W-1:0] crs_i,
  input  logic [TAP_W-1:0] tmax_i,
  output logic [PI_W-1:0]  pi_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [CLK_W-1:0] clk_o,
  output logic [CRS_W-1:0] crs_o,
  output logic             ok_o
);
  localparam logic [PI_W-1:0]  PiTop   = PI_W'(PI_TOP);
  localparam logic [CLK_W-1:0] ClkCeil = CLK_W'(CLK_CEIL);
  localparam logic [CRS_W-1:0] CrsTop  = CRS_W'(CRS_TOP);

  always_comb begin
    pi_o  = pi_i;
    tap_o = tap_i;
    clk_o = clk_i;
    crs_o = crs_i;
    ok_o  = 1'b1;
    if (pi_i < PiTop) begin
      pi_o = pi_i + PI_W'(1);
    end else if (tap_i < tmax_i) begin
      pi_o  = '0;
      tap_o = tap_i + TAP_W'(1);
    end else if (clk_i < ClkCeil) begin
      pi_o  = '0;
      tap_o = '0;
      clk_o = clk_i + CLK_W'(1);
    end else if (crs_i < CrsTop) begin
      pi_o  = '0;
      tap_o = '0;
      clk_o = ClkCeil - CLK_W'(1);
      crs_o = crs_i + CRS_W'(1);
    end else begin
      ok_o = 1'b0;
    end
  end
endmodule

// File: rtl/dly_step_unit.sv
module dly_step_unit
  import dly_step_pkg::*;
#(
  parameter int PI_W      = 3,
  parameter int TAP_W     = 5,
  parameter int CLK_W     = 3,
  parameter int CRS_W     = 2,
  parameter int PI_TOP    = 6,
  parameter int CLK_CEIL  = 5,
  parameter int CRS_TOP   = 3,
  parameter int TAP_M800  = 12,
  parameter int TAP_M1066 = 14,
  parameter int TAP_M1333 = 18,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [1:0]       spd_i,
  input  logic             ld_i,
  input  logic [CRS_W-1:0] ld_crs_i,
  input  logic [CLK_W-1:0] ld_clk_i,
  input  logic [TAP_W-1:0] ld_tap_i,
  input  logic [PI_W-1:0]  ld_pi_i,
  output logic [CRS_W-1:0] crs_o,
  output logic [CLK_W-1:0] clk_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [PI_W-1:0]  pi_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int FW = PI_W + TAP_W + CLK_W + CRS_W;

  // reset: asserted asynchronously, released through a short synchronizer
  logic [SYNC_STG-1:0] rst_pipe_q;
  logic                rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= '0;
    else          rst_pipe_q <= {rst_pipe_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STG-1];

  logic [TAP_W-1:0] tmax;

  dly_tap_limit #(
    .TAP_W(TAP_W), .TAP_M800(TAP_M800), .TAP_M1066(TAP_M1066), .TAP_M1333(TAP_M1333)
  ) u_tlim (
    .spd_i(spd_i), .tmax_o(tmax)
  );

  logic [PI_W-1:0]  dec_pi,  inc_pi;
  logic [TAP_W-1:0] dec_tap, inc_tap;
  logic [CLK_W-1:0] dec_clk, inc_clk;
  logic [CRS_W-1:0] dec_crs, inc_crs;
  logic             dec_ok,  inc_ok;

  dly_step_dec #(
    .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W), .CRS_W(CRS_W), .PI_TOP(PI_TOP)
  ) u_dec (
    .pi_i(pi_o), .tap_i(tap_o), .clk_i(clk_o), .crs_i(crs_o), .tmax_i(tmax),
    .pi_o(dec_pi), .tap_o(dec_tap), .clk_o(dec_clk), .crs_o(dec_crs), .ok_o(dec_ok)
  );

  dly_step_inc #(
    .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W), .CRS_W(CRS_W), .PI_TOP(PI_TOP),
    .CLK_CEIL(CLK_CEIL), .CRS_TOP(CRS_TOP)
  ) u_inc (
    .pi_i(pi_o), .tap_i(tap_o), .clk_i(clk_o), .crs_i(crs_o), .tmax_i(tmax),
    .pi_o(inc_pi), .tap_o(inc_tap), .clk_o(inc_clk), .crs_o(inc_crs), .ok_o(inc_ok)
  );

  // next-state selection
  op_e           op;
  logic [FW-1:0] fld_d;
  logic          fld_en;
  logic          done_d, err_d;

  always_comb begin
    if (ld_i)      op = OP_LOAD;
    else if (dn_i) op = OP_DEC;
    else if (up_i) op = OP_INC;
    else           op = OP_HOLD;

    fld_d  = {crs_o, clk_o, tap_o, pi_o};
    fld_en = 1'b0;
    done_d = 1'b0;
    err_d  = 1'b0;
    case (op)
      OP_LOAD: begin
        fld_d  = {ld_crs_i, ld_clk_i, ld_tap_i, ld_pi_i};
        fld_en = 1'b1;
      end
      OP_DEC: begin
        fld_d  = {dec_crs, dec_clk, dec_tap, dec_pi};
        fld_en = dec_ok;
        done_d = dec_ok;
        err_d  = !dec_ok;
      end
      OP_INC: begin
        fld_d  = {inc_crs, inc_clk, inc_tap, inc_pi};
        fld_en = inc_ok;
        done_d = inc_ok;
        err_d  = !inc_ok;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      {crs_o, clk_o, tap_o, pi_o} <= '0;
    end else if (fld_en) begin
      {crs_o, clk_o, tap_o, pi_o} <= fld_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/dly_step_unit_chk.sv
module dly_step_unit_chk #(
  parameter int PI_W  = 3,
  parameter int TAP_W = 5,
  parameter int CLK_W = 3,
  parameter int CRS_W = 2
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             up_i,
  input logic             dn_i,
  input logic             ld_i,
  input logic [CRS_W-1:0] ld_crs_i,
  input logic [CLK_W-1:0] ld_clk_i,
  input logic [TAP_W-1:0] ld_tap_i,
  input logic [PI_W-1:0]  ld_pi_i,
  input logic [CRS_W-1:0] crs_o,
  input logic [CLK_W-1:0] clk_o,
  input logic [TAP_W-1:0] tap_o,
  input logic [PI_W-1:0]  pi_o,
  input logic             done_o,
  input logic             err_o
);
  logic all_zero;
  assign all_zero = (crs_o == '0) && (clk_o == '0) && (tap_o == '0) && (pi_o == '0);

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld_i |=> ({crs_o, clk_o, tap_o, pi_o} == $past({ld_crs_i, ld_clk_i, ld_tap_i, ld_pi_i}))
             && !done_o && !err_o); // R2

  AST_DEC_PI_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ld_i && dn_i && pi_o != '0) |=> (pi_o == $past(pi_o) - PI_W'(1))
      && $stable(tap_o) && $stable(clk_o) && $stable(crs_o)); // R3

  AST_FLOOR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ld_i && dn_i && all_zero) |=> err_o && !done_o && all_zero); // R7

  AST_ERR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> $stable(crs_o) && $stable(clk_o) && $stable(tap_o) && $stable(pi_o)); // R9

  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !err_o && $past(up_i || dn_i) && !$past(ld_i)); // R11

  AST_DN_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ld_i && dn_i && up_i && pi_o != '0) |=> (pi_o == $past(pi_o) - PI_W'(1))); // R12
endmodule

bind dly_step_unit dly_step_unit_chk #(
  .PI_W(PI_W), .TAP_W(TAP_W), .CLK_W(CLK_W), .CRS_W(CRS_W)
) u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .up_i(up_i), .dn_i(dn_i), .ld_i(ld_i),
  .ld_crs_i(ld_crs_i), .ld_clk_i(ld_clk_i), .ld_tap_i(ld_tap_i), .ld_pi_i(ld_pi_i),
  .crs_o(crs_o), .clk_o(clk_o), .tap_o(tap_o), .pi_o(pi_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/dly_step_unit_tb.sv
module dly_step_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic       up_i, dn_i, ld_i;
  logic [1:0] spd_i;
  logic [1:0] ld_crs_i;
  logic [2:0] ld_clk_i;
  logic [4:0] ld_tap_i;
  logic [2:0] ld_pi_i;
  logic [1:0] crs_o;
  logic [2:0] clk_o;
  logic [4:0] tap_o;
  logic [2:0] pi_o;
  logic       done_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  dly_step_unit u_dut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .up_i(up_i), .dn_i(dn_i), .spd_i(spd_i),
    .ld_i(ld_i), .ld_crs_i(ld_crs_i), .ld_clk_i(ld_clk_i), .ld_tap_i(ld_tap_i),
    .ld_pi_i(ld_pi_i), .crs_o(crs_o), .clk_o(clk_o), .tap_o(tap_o), .pi_o(pi_o),
    .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [31:0] pk(input int c, input int k, input int t, input int p);
    return {19'd0, 2'(c), 3'(k), 5'(t), 3'(p)};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_set(input string req, input int c, input int k, input int t, input int p);
    chk(req, {19'd0, crs_o, clk_o, tap_o, pi_o}, pk(c, k, t, p));
  endtask

  task automatic load(input int c, input int k, input int t, input int p);
    @(negedge clk_i);
    ld_i = 1'b1; ld_crs_i = 2'(c); ld_clk_i = 3'(k); ld_tap_i = 5'(t); ld_pi_i = 3'(p);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  task automatic step(input logic u, input logic d);
    @(negedge clk_i);
    up_i = u; dn_i = d;
    @(negedge clk_i);
    up_i = 1'b0; dn_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_set("R1 fields", 0, 0, 0, 0);
    chk("R1 done/err", {30'd0, done_o, err_o}, 32'd0);
  endtask

  task automatic t_floor;
    step(1'b0, 1'b1);
    chk_set("R7 setting", 0, 0, 0, 0);
    chk("R7 err/done", {30'd0, err_o, done_o}, 32'd2);
  endtask

  task automatic t_down_cases;
    spd_i = 2'b00;
    load(1, 0, 0, 0);
    step(1'b0, 1'b1);
    chk_set("R6 coarse borrow", 0, 1, 12, 6);
    chk("R11 done", {31'd0, done_o}, 32'd1);
    @(negedge clk_i);
    chk("R11 single pulse", {31'd0, done_o}, 32'd0);
    step(1'b0, 1'b1);
    chk_set("R3 pi only", 0, 1, 12, 5);
    load(0, 0, 3, 0);
    step(1'b0, 1'b1);
    chk_set("R4 tap borrow", 0, 0, 2, 6);
    spd_i = 2'b01;
    load(0, 2, 0, 0);
    step(1'b0, 1'b1);
    chk_set("R5 clk borrow", 0, 1, 14, 6);
  endtask

  task automatic t_speeds;
    spd_i = 2'b10;
    load(0, 1, 0, 0);
    step(1'b0, 1'b1);
    chk_set("R10 speed 2", 0, 0, 18, 6);
    spd_i = 2'b11;
    load(0, 1, 0, 0);
    step(1'b0, 1'b1);
    chk_set("R10 speed 3", 0, 0, 12, 6);
    spd_i = 2'b01;
    load(0, 0, 13, 6);
    step(1'b1, 1'b0);
    chk_set("R10 up to speed 1 max", 0, 0, 14, 0);
  endtask

  task automatic t_up_cases;
    spd_i = 2'b00;
    load(0, 0, 0, 2);
    step(1'b1, 1'b0);
    chk_set("R8 pi inc", 0, 0, 0, 3);
    load(0, 0, 3, 6);
    step(1'b1, 1'b0);
    chk_set("R8 tap carry", 0, 0, 4, 0);
    load(0, 0, 12, 6);
    step(1'b1, 1'b0);
    chk_set("R8 clk carry", 0, 1, 0, 0);
    load(1, 5, 12, 6);
    step(1'b1, 1'b0);
    chk_set("R8 coarse carry", 2, 4, 0, 0);
    chk("R11 done up", {31'd0, done_o}, 32'd1);
    load(3, 5, 12, 6);
    step(1'b1, 1'b0);
    chk_set("R9 ceiling held", 3, 5, 12, 6);
    chk("R9 err/done", {30'd0, err_o, done_o}, 32'd2);
  endtask

  task automatic t_priority;
    load(0, 0, 0, 3);
    step(1'b1, 1'b1);
    chk_set("R12 down wins", 0, 0, 0, 2);
    @(negedge clk_i);
    ld_i = 1'b1; dn_i = 1'b1; ld_crs_i = 2'd2; ld_clk_i = 3'd3; ld_tap_i = 5'd7; ld_pi_i = 3'd1;
    @(negedge clk_i);
    ld_i = 1'b0; dn_i = 1'b0;
    chk_set("R2 load wins", 2, 3, 7, 1);
    chk("R2 no pulse", {30'd0, done_o, err_o}, 32'd0);
  endtask

  initial begin
    rst_n_i = 1'b0; up_i = 1'b0; dn_i = 1'b0; ld_i = 1'b0; spd_i = 2'b00;
    ld_crs_i = '0; ld_clk_i = '0; ld_tap_i = '0; ld_pi_i = '0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_floor();
    t_down_cases();
    t_speeds();
    t_up_cases();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule